// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the register front end of an interrupt distributor. A requester on a simple register port issues single-cycle read or write requests. Each request carries a byte address, a 32-bit data word and four byte-lane strobes. Reads complete one cycle later. The block holds the global control word, which contains the group-1 enable and the hardware-SGI request flag. It computes the type, type-2 and implementation-ID words from parameters and one input. It answers the identification range. It also keeps one 64-bit routing register per shared interrupt, and only the 24-bit target affinity of that register is stored.

The per-interrupt windows (group, enable, pending, active, priority, target, configuration and group-modifier) are only decoded here. Accesses to slots that belong to the 32 private interrupt numbers are absorbed: they read as zero and their writes go nowhere. Accesses to shared-interrupt slots are handed to external state storage through a hit strobe with a window index and a byte offset. The read data for those slots comes back on an input. The enable flag, the hardware-SGI request flag and every stored affinity are exported as outputs.

Top module: `dist_regbank`

## Requirements
- R1: A read of the control word (address 0x000) always returns bit 4 (affinity routing) and bit 6 (security disabled) set. Bit 1 shows the stored group-1 enable, bit 25 shows the stored hardware-SGI request, and all other bits read zero. The reset value is therefore 0x00000050.
- R2: A control write takes bit 1 from byte lane 0 and bit 25 from byte lane 3. A lane whose strobe is clear leaves its flag as it was. When `sgi_cap_i` is low and the distributor was disabled before the write, the hardware-SGI request becomes zero whatever is written.
- R3: When the distributor is enabled before a control write and is still enabled after it, the hardware-SGI request keeps its previous value.
- R4: The type word (address 0x004) carries ((NUM_SPI + 32) >> 5) − 1 in bits [4:0]. Bits [23:19] hold the ID width minus one: LPI_ID_BITS when HAS_ITS = 1, and ID_BITS otherwise. Bit 17 is set when HAS_ITS = 1.
- R5: The type-2 word (0x008) reports `sgi_cap_i` in bit 8. The implementation-ID word (0x00C) returns the parameter IIDR_VAL. Writes to 0x004, 0x008 and 0x00C change nothing.
- R6: The routing register of interrupt n (32 ≤ n < 32 + NUM_SPI) sits at 0x6000 + 8·n. A write to its lower word stores byte lanes 0 to 2 into the affinity of that interrupt and drops lane 3. The affinity reads back in bits [23:0] and appears on `route_aff_o` at bits [24·(n−32) +: 24].
- R7: The upper word of every routing register (address bit 2 set) reads zero and ignores writes. Routing slots for n < 32 or n ≥ 32 + NUM_SPI also read zero and ignore writes.
- R8: The windows are laid out as follows. The 1-bit windows sit at 0x080, 0x100, 0x180, 0x200, 0x280, 0x300, 0x380 and 0xD00 (indices 0 to 6 and 10). The 8-bit windows sit at 0x400 and 0x800 (indices 7 and 8), and the 2-bit window sits at 0xC00 (index 9). Offsets below bpi·4 bytes, and offsets at or beyond bpi·(32+NUM_SPI)/8 bytes, read zero, ignore writes and leave `win_hit_o` low. All other offsets raise `win_hit_o` in the request cycle, with the window index and the offset from the window base.
- R9: The identification range 0xFFD0 to 0xFFFF reads 0x3B at 0xFFE8 and zero everywhere else. Any address not covered above also reads zero.
- R10: `rsp_valid_o` pulses in the cycle after each read request. `rsp_data_o` is the addressed word shifted right by 8·addr[1:0].
- R11: Reset clears the enable, the hardware-SGI request and all affinities to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte-lane write strobes |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_data_o | output | 32 | Read data, shifted by byte offset |
| sgi_cap_i | input | 1 | Hardware SGI injection is available |
| dist_en_o | output | 1 | Group-1 enable |
| hwsgi_req_o | output | 1 | Hardware-SGI request flag |
| route_aff_o | output | 24·NUM_SPI | Stored affinity per shared interrupt |
| win_hit_o | output | 1 | Access targets a shared slot of a per-interrupt window |
| win_idx_o | output | 4 | Index of that window |
| win_off_o | output | ADDR_W | Byte offset from the window base |
| win_rdata_i | input | 32 | Read data from external per-interrupt storage |

## Verification
The bench builds the block with NUM_SPI = 64 and HAS_ITS = 1. This exercises the LPI bit and the wider ID field of the type word, and it leaves shared slots beyond the last implemented interrupt inside each window, so the upper edge of the usable range can be probed. Interrupts 32 and 95 are the first and last routing entries, and interrupt 96 lies just outside them. The control sequence steps `sgi_cap_i` through both values while the enable stays on, stays off and changes, which covers the order of the gating and locking rules.

// File: rtl/dist_pkg.sv
package dist_pkg;

   localparam int unsigned PRIV_IRQS   = 32;
   localparam int unsigned NUM_WIN     = 11;
   localparam int unsigned ROUTE_BASE  = 32'h6000;
   localparam int unsigned ROUTE_LEN   = 32'h2000;
   localparam int unsigned ID_FIRST    = 32'hFFD0;
   localparam int unsigned ID_LAST     = 32'hFFFF;
   localparam int unsigned ID_PERIPH2  = 32'hFFE8;
   localparam logic [31:0] ID_PERIPH2_VAL = 32'h0000_003B;

   // control word bit positions
   localparam int unsigned CTL_EN_BIT    = 1;
   localparam int unsigned CTL_ARE_BIT   = 4;
   localparam int unsigned CTL_DS_BIT    = 6;
   localparam int unsigned CTL_HWSGI_BIT = 25;
   // type words
   localparam int unsigned TYP_LPI_BIT   = 17;
   localparam int unsigned TYP_IDB_LSB   = 19;
   localparam int unsigned TYP2_CAP_BIT  = 8;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_MISC,
      RG_WIN,
      RG_ROUTE,
      RG_IDREG
   } region_e;

   function automatic int unsigned win_base(input int unsigned k);
      case (k)
         0:  return 32'h080;
         1:  return 32'h100;
         2:  return 32'h180;
         3:  return 32'h200;
         4:  return 32'h280;
         5:  return 32'h300;
         6:  return 32'h380;
         7:  return 32'h400;
         8:  return 32'h800;
         9:  return 32'hC00;
         default: return 32'hD00;
      endcase
   endfunction

   function automatic int unsigned win_bpi(input int unsigned k);
      case (k)
         7, 8:    return 8;
         9:       return 2;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/dist_addr_decode.sv
module dist_addr_decode
   import dist_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned NUM_SPI = 64,
   parameter int unsigned IDX_W   = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [1:0]        misc_sel,
   output logic [3:0]        win_idx,
   output logic [ADDR_W-1:0] win_off,
   output logic              win_shared,
   output logic [IDX_W-1:0]  route_idx,
   output logic              route_ok,
   output logic              route_hi,
   output logic              pidr2_hit
);

   localparam int unsigned TOTAL_IRQ = NUM_SPI + PRIV_IRQS;

   logic [31:0]        a32;
   logic [NUM_WIN-1:0] win_hit_vec;
   logic [NUM_WIN-1:0] win_shr_vec;
   logic [31:0]        win_rel [NUM_WIN];
   logic               in_misc, in_route, in_id;
   logic [31:0]        r_rel;
   logic [9:0]         intid;
   logic [9:0]         spi_num;

   assign a32 = 32'(addr);

   for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
      localparam int unsigned BASE = win_base(k);
      localparam int unsigned BPI  = win_bpi(k);
      localparam int unsigned LEN  = BPI * 128;
      localparam int unsigned PRIV = BPI * PRIV_IRQS / 8;
      localparam int unsigned USE  = BPI * TOTAL_IRQ / 8;
      assign win_rel[k]     = a32 - BASE;
      assign win_hit_vec[k] = (a32 >= BASE) && (a32 < BASE + LEN);
      assign win_shr_vec[k] = (win_rel[k] >= PRIV) && (win_rel[k] < USE);
   end

   always_comb begin
      win_idx    = '0;
      win_off    = '0;
      win_shared = 1'b0;
      for (int k = 0; k < NUM_WIN; k++) begin
         if (win_hit_vec[k]) begin
            win_idx    = 4'(k);
            win_off    = win_rel[k][ADDR_W-1:0];
            win_shared = win_shr_vec[k];
         end
      end
   end

   assign in_misc  = a32 < 32'd16;
   assign misc_sel = addr[3:2];

   assign in_route  = (a32 >= ROUTE_BASE) && (a32 < ROUTE_BASE + ROUTE_LEN);
   assign r_rel     = a32 - ROUTE_BASE;
   assign intid     = r_rel[12:3];
   assign route_hi  = r_rel[2];
   assign route_ok  = in_route && (32'(intid) >= PRIV_IRQS) && (32'(intid) < TOTAL_IRQ);
   assign spi_num   = intid - 10'(PRIV_IRQS);
   assign route_idx = spi_num[IDX_W-1:0];

   assign in_id     = (a32 >= ID_FIRST) && (a32 <= ID_LAST);
   assign pidr2_hit = (a32 == ID_PERIPH2);

   always_comb begin
      if (in_misc)           region = RG_MISC;
      else if (|win_hit_vec) region = RG_WIN;
      else if (in_route)     region = RG_ROUTE;
      else if (in_id)        region = RG_IDREG;
      else                   region = RG_NONE;
   end

   // address regions never overlap
   always_comb begin
      if (!$isunknown(addr))
         assert_region_onehot_R8: assert ($onehot0({win_hit_vec, in_misc, in_route, in_id}));
   end

endmodule

// File: rtl/dist_ctrl_regs.sv
module dist_ctrl_regs
   import dist_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [31:0] wdata,
   input  logic [3:0]  be,
   input  logic        sgi_cap,
   output logic        en_q,
   output logic        hwsgi_q
);

   logic nxt_en, nxt_req;

   always_comb begin
      nxt_en  = be[CTL_EN_BIT/8]    ? wdata[CTL_EN_BIT]    : en_q;
      nxt_req = be[CTL_HWSGI_BIT/8] ? wdata[CTL_HWSGI_BIT] : hwsgi_q;
      if (!sgi_cap)
         nxt_req = 1'b0;
      if (en_q && nxt_en)
         nxt_req = hwsgi_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         hwsgi_q <= 1'b0;
      end else if (we) begin
         en_q    <= nxt_en;
         hwsgi_q <= nxt_req;
      end
   end

   assert_cap_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !sgi_cap && !en_q) |=> !hwsgi_q);

   assert_sgi_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && en_q) |=> (!en_q || (hwsgi_q == $past(hwsgi_q))));

endmodule

// File: rtl/dist_route_bank.sv
module dist_route_bank #(
   parameter int unsigned NUM_SPI = 64,
   parameter int unsigned AFF_W   = 24,
   parameter int unsigned IDX_W   = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic                     hi,
   input  logic [IDX_W-1:0]         idx,
   input  logic [31:0]              wdata,
   input  logic [3:0]               be,
   output logic [NUM_SPI*AFF_W-1:0] aff_flat,
   output logic [AFF_W-1:0]         rd_aff
);

   localparam int unsigned LANES = AFF_W / 8;

   for (genvar s = 0; s < NUM_SPI; s++) begin : g_ent
      logic [AFF_W-1:0] aff_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            aff_q <= '0;
         else if (we && !hi && (idx == IDX_W'(s))) begin
            for (int l = 0; l < LANES; l++)
               if (be[l]) aff_q[l*8 +: 8] <= wdata[l*8 +: 8];
         end
      end
      assign aff_flat[s*AFF_W +: AFF_W] = aff_q;
   end

   always_comb begin
      rd_aff = '0;
      for (int s = 0; s < NUM_SPI; s++)
         if (idx == IDX_W'(s)) rd_aff = aff_flat[s*AFF_W +: AFF_W];
   end

   assert_upper_word_wi_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && hi) |=> $stable(aff_flat));

endmodule

// File: rtl/dist_regbank.sv
module dist_regbank
   import dist_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned NUM_SPI     = 64,
   parameter bit          HAS_ITS     = 1'b0,
   parameter int unsigned ID_BITS     = 10,
   parameter int unsigned LPI_ID_BITS = 16,
   parameter logic [31:0] IIDR_VAL    = 32'h0200_0A3D
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_i,
   input  logic                  we_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [31:0]           wdata_i,
   input  logic [3:0]            be_i,
   output logic                  rsp_valid_o,
   output logic [31:0]           rsp_data_o,
   input  logic                  sgi_cap_i,
   output logic                  dist_en_o,
   output logic                  hwsgi_req_o,
   output logic [NUM_SPI*24-1:0] route_aff_o,
   output logic                  win_hit_o,
   output logic [3:0]            win_idx_o,
   output logic [ADDR_W-1:0]     win_off_o,
   input  logic [31:0]           win_rdata_i
);

   localparam int unsigned AFF_W     = 24;
   localparam int unsigned IDX_W     = $clog2(NUM_SPI);
   localparam int unsigned LINES_FLD = ((NUM_SPI + PRIV_IRQS) >> 5) - 1;

   if (ADDR_W < 16) begin : g_bad_addr
      $error("ADDR_W must cover the 64 KiB frame");
   end
   if ((NUM_SPI < 32) || (NUM_SPI > 988) || (NUM_SPI % 32 != 0)) begin : g_bad_spi
      $error("NUM_SPI must be a multiple of 32 between 32 and 988");
   end
   if ((ID_BITS < 5) || (ID_BITS > 32) || (LPI_ID_BITS < 14) || (LPI_ID_BITS > 32)) begin : g_bad_idb
      $error("ID width parameters out of range");
   end

   region_e              region;
   logic [1:0]           misc_sel;
   logic [3:0]           dec_win_idx;
   logic [ADDR_W-1:0]    dec_win_off;
   logic                 win_shared;
   logic [IDX_W-1:0]     route_idx;
   logic                 route_ok, route_hi, pidr2_hit;
   logic                 en_q, hwsgi_q;
   logic [AFF_W-1:0]     rd_aff;
   logic [31:0]          ctrl_word, type_word, type2_word, rd_word;
   logic                 is_wr, is_rd;

   assign is_wr = req_i && we_i;
   assign is_rd = req_i && !we_i;

   dist_addr_decode #(
      .ADDR_W (ADDR_W),
      .NUM_SPI(NUM_SPI),
      .IDX_W  (IDX_W)
   ) u_dec (
      .addr      (addr_i),
      .region    (region),
      .misc_sel  (misc_sel),
      .win_idx   (dec_win_idx),
      .win_off   (dec_win_off),
      .win_shared(win_shared),
      .route_idx (route_idx),
      .route_ok  (route_ok),
      .route_hi  (route_hi),
      .pidr2_hit (pidr2_hit)
   );

   dist_ctrl_regs u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (is_wr && (region == RG_MISC) && (misc_sel == 2'd0)),
      .wdata  (wdata_i),
      .be     (be_i),
      .sgi_cap(sgi_cap_i),
      .en_q   (en_q),
      .hwsgi_q(hwsgi_q)
   );

   dist_route_bank #(
      .NUM_SPI(NUM_SPI),
      .AFF_W  (AFF_W),
      .IDX_W  (IDX_W)
   ) u_route (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (is_wr && (region == RG_ROUTE) && route_ok),
      .hi      (route_hi),
      .idx     (route_idx),
      .wdata   (wdata_i),
      .be      (be_i),
      .aff_flat(route_aff_o),
      .rd_aff  (rd_aff)
   );

   always_comb begin
      ctrl_word                = '0;
      ctrl_word[CTL_ARE_BIT]   = 1'b1;
      ctrl_word[CTL_DS_BIT]    = 1'b1;
      ctrl_word[CTL_EN_BIT]    = en_q;
      ctrl_word[CTL_HWSGI_BIT] = hwsgi_q;
   end

   if (HAS_ITS) begin : g_type_lpi
      assign type_word = 32'(LINES_FLD) | (32'(LPI_ID_BITS - 1) << TYP_IDB_LSB)
                       | (32'd1 << TYP_LPI_BIT);
   end else begin : g_type_plain
      assign type_word = 32'(LINES_FLD) | (32'(ID_BITS - 1) << TYP_IDB_LSB);
   end

   always_comb begin
      type2_word               = '0;
      type2_word[TYP2_CAP_BIT] = sgi_cap_i;
   end

   always_comb begin
      rd_word = '0;
      unique case (region)
         RG_MISC: begin
            case (misc_sel)
               2'd0:    rd_word = ctrl_word;
               2'd1:    rd_word = type_word;
               2'd2:    rd_word = type2_word;
               default: rd_word = IIDR_VAL;
            endcase
         end
         RG_WIN:   rd_word = win_shared ? win_rdata_i : '0;
         RG_ROUTE: rd_word = (route_ok && !route_hi) ? 32'(rd_aff) : '0;
         RG_IDREG: rd_word = pidr2_hit ? ID_PERIPH2_VAL : '0;
         default:  rd_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_o <= 1'b0;
         rsp_data_o  <= '0;
      end else begin
         rsp_valid_o <= is_rd;
         if (is_rd)
            rsp_data_o <= rd_word >> {addr_i[1:0], 3'b000};
      end
   end

   assign win_hit_o   = req_i && (region == RG_WIN) && win_shared;
   assign win_idx_o   = dec_win_idx;
   assign win_off_o   = dec_win_off;
   assign dist_en_o   = en_q;
   assign hwsgi_req_o = hwsgi_q;

   assert_rsp_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd |=> rsp_valid_o);

   assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !is_rd |=> !rsp_valid_o);

endmodule

// File: tb/sim_dist_regbank.sv
module sim_dist_regbank;

   localparam int CLK_P   = 10;
   localparam int AW      = 16;
   localparam int NSPI    = 64;
   localparam bit HAS     = 1'b1;
   localparam int IDB     = 10;
   localparam int LIDB    = 16;
   localparam logic [31:0] IIDR = 32'h0200_0A3D;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req = 1'b0, we = 1'b0;
   logic [AW-1:0]     addr = '0;
   logic [31:0]       wdata = '0;
   logic [3:0]        be = '0;
   logic              rsp_valid;
   logic [31:0]       rsp_data;
   logic              sgi_cap = 1'b0;
   logic              dist_en, hwsgi;
   logic [NSPI*24-1:0] aff;
   logic              win_hit;
   logic [3:0]        win_idx;
   logic [AW-1:0]     win_off;
   logic [31:0]       win_rdata;

   int n_cmp = 0, n_bad = 0;
   bit chk_on = 1'b0;

   // reference model state
   bit           en_m, sgi_m;
   logic [23:0]  aff_m [NSPI];

   always #(CLK_P/2) clk = ~clk;
   assign win_rdata = {16'hC0DE, win_off};

   dist_regbank #(
      .ADDR_W(AW), .NUM_SPI(NSPI), .HAS_ITS(HAS), .ID_BITS(IDB),
      .LPI_ID_BITS(LIDB), .IIDR_VAL(IIDR)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
      .wdata_i(wdata), .be_i(be), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
      .sgi_cap_i(sgi_cap), .dist_en_o(dist_en), .hwsgi_req_o(hwsgi),
      .route_aff_o(aff), .win_hit_o(win_hit), .win_idx_o(win_idx),
      .win_off_o(win_off), .win_rdata_i(win_rdata)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // window table of the bench: base, bits per interrupt
   function automatic int wbase(int k);
      int t[11] = '{'h080,'h100,'h180,'h200,'h280,'h300,'h380,'h400,'h800,'hC00,'hD00};
      return t[k];
   endfunction
   function automatic int wbpi(int k);
      int t[11] = '{1,1,1,1,1,1,1,8,8,2,1};
      return t[k];
   endfunction

   // returns 1 when the address is a forwarded shared slot; off = offset from base
   function automatic bit model_win(int a, output int off, output int idx);
      off = 0; idx = 0;
      for (int k = 0; k < 11; k++) begin
         if (a >= wbase(k) && a < wbase(k) + wbpi(k)*128) begin
            off = a - wbase(k); idx = k;
            return (off >= wbpi(k)*4) && (off < wbpi(k)*(32+NSPI)/8);
         end
      end
      return 0;
   endfunction

   function automatic logic [31:0] model_read(int a);
      logic [31:0] w = 0;
      int off, idx, n;
      if (a < 16) begin
         case ((a >> 2) & 3)
            0: w = 32'h50 | (32'(en_m) << 1) | (32'(sgi_m) << 25);
            1: w = 32'(((NSPI + 32) / 32) - 1) | (32'((HAS ? LIDB : IDB) - 1) << 19)
                   | (32'(HAS) << 17);
            2: w = 32'(sgi_cap) << 8;
            default: w = IIDR;
         endcase
      end else if (model_win(a, off, idx)) begin
         w = {16'hC0DE, 16'(off)};
      end else if (a >= 'h6000 && a < 'h8000) begin
         n = (a - 'h6000) / 8;
         if (n >= 32 && n < 32 + NSPI && ((a & 4) == 0)) w = 32'(aff_m[n-32]);
      end else if (a == 'hFFE8) begin
         w = 32'h3B;
      end
      return w >> (8 * (a & 3));
   endfunction

   task automatic model_write(int a, logic [31:0] d, logic [3:0] b);
      int off, idx, n;
      bit ne, nr;
      if (a < 16 && ((a >> 2) & 3) == 0) begin
         ne = b[0] ? d[1] : en_m;
         nr = b[3] ? d[25] : sgi_m;
         if (!sgi_cap) nr = 0;
         if (en_m && ne) nr = sgi_m;
         en_m = ne; sgi_m = nr;
      end else if (a >= 'h6000 && a < 'h8000 && !model_win(a, off, idx)) begin
         n = (a - 'h6000) / 8;
         if (n >= 32 && n < 32 + NSPI && ((a & 4) == 0))
            for (int l = 0; l < 3; l++)
               if (b[l]) aff_m[n-32][l*8 +: 8] = d[l*8 +: 8];
      end
   endtask

   task automatic access(input string tag, input bit w, input int a,
                         input logic [31:0] d, input logic [3:0] b);
      int off, idx;
      bit hit;
      logic [31:0] exp;
      @(negedge clk);
      req = 1'b1; we = w; addr = AW'(a); wdata = d; be = b;
      hit = model_win(a, off, idx);
      exp = model_read(a);
      #1;
      check({tag, " win_hit"}, 32'(win_hit), 32'(hit));
      if (hit) begin
         check({tag, " win_idx"}, 32'(win_idx), 32'(idx));
         check({tag, " win_off"}, 32'(win_off), 32'(off));
      end
      @(posedge clk);
      if (w) model_write(a, d, b);
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      check({tag, " rsp_valid R10"}, 32'(rsp_valid), 32'(!w));
      if (!w) check({tag, " rdata"}, rsp_data, exp);
   endtask

   task automatic do_reset;
      chk_on = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      en_m = 0; sgi_m = 0;
      for (int s = 0; s < NSPI; s++) aff_m[s] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_on = 1'b1;
   endtask

   // compare exported state with the model on every clock
   always @(negedge clk) begin
      if (chk_on) begin
         check("R1 enable out", 32'(dist_en), 32'(en_m));
         check("R3 hwsgi out", 32'(hwsgi), 32'(sgi_m));
         for (int s = 0; s < NSPI; s++)
            check("R6 affinity out", 32'(aff[s*24 +: 24]), 32'(aff_m[s]));
      end
   end

   initial begin
      #(CLK_P * 20000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      // R11 / R1: reset state
      access("R11 ctrl after reset", 0, 'h000, 0, 0);
      access("R11 route after reset", 0, 'h6100, 0, 0);
      // R4 / R5 identification words
      access("R4 type word", 0, 'h004, 0, 0);
      access("R5 type2 cap0", 0, 'h008, 0, 0);
      sgi_cap = 1'b1;
      access("R5 type2 cap1", 0, 'h008, 0, 0);
      access("R5 iidr", 0, 'h00C, 0, 0);
      access("R5 type write", 1, 'h004, 32'hFFFF_FFFF, 4'hF);
      access("R5 iidr write", 1, 'h00C, 32'h1234_5678, 4'hF);
      access("R5 type reread", 0, 'h004, 0, 0);
      access("R5 iidr reread", 0, 'h00C, 0, 0);
      // R2 / R3 control sequence
      sgi_cap = 1'b0;
      access("R2 enable no cap", 1, 'h000, 32'h0200_0002, 4'hF);
      access("R1 ctrl read", 0, 'h000, 0, 0);
      access("R2 disable", 1, 'h000, 32'h0, 4'hF);
      sgi_cap = 1'b1;
      access("R2 enable with cap", 1, 'h000, 32'h0200_0002, 4'hF);
      access("R3 stay enabled clear req", 1, 'h000, 32'h0000_0002, 4'hF);
      access("R3 ctrl read locked", 0, 'h000, 0, 0);
      sgi_cap = 1'b0;
      access("R3 locked without cap", 1, 'h000, 32'h0000_0002, 4'hF);
      access("R2 disable clears", 1, 'h000, 32'h0, 4'hF);
      sgi_cap = 1'b1;
      access("R2 req while disabled", 1, 'h000, 32'h0200_0000, 4'hF);
      access("R2 lane0 only enable", 1, 'h000, 32'h0000_0002, 4'h1);
      access("R1 ctrl byte offset", 0, 'h003, 0, 0);
      // R6 / R7 routing
      access("R6 write first spi", 1, 'h6100, 32'hFFAB_CDEF, 4'hF);
      access("R6 read first spi", 0, 'h6100, 0, 0);
      access("R10 read shifted", 0, 'h6101, 0, 0);
      access("R7 upper read", 0, 'h6104, 0, 0);
      access("R7 upper write", 1, 'h6104, 32'h0011_2233, 4'hF);
      access("R6 partial lane", 1, 'h6100, 32'h0000_5500, 4'h2);
      access("R6 reread partial", 0, 'h6100, 0, 0);
      access("R6 write last spi", 1, 'h6000 + 8*95, 32'h0012_3456, 4'hF);
      access("R6 read last spi", 0, 'h6000 + 8*95, 0, 0);
      access("R7 private route write", 1, 'h6000 + 8*5, 32'h00AA_AAAA, 4'hF);
      access("R7 private route read", 0, 'h6000 + 8*5, 0, 0);
      access("R7 beyond last write", 1, 'h6000 + 8*96, 32'h00BB_BBBB, 4'hF);
      access("R7 beyond last read", 0, 'h6000 + 8*96, 0, 0);
      // R8 windows
      access("R8 private group read", 0, 'h080, 0, 0);
      access("R8 private enable write", 1, 'h100, 32'hFFFF_FFFF, 4'hF);
      access("R8 shared group read", 0, 'h084, 0, 0);
      access("R8 shared edge", 0, 'h088, 0, 0);
      access("R8 beyond usable", 0, 'h08C, 0, 0);
      access("R8 private priority", 0, 'h410, 0, 0);
      access("R8 shared priority", 0, 'h420, 0, 0);
      access("R8 shared target write", 1, 'h824, 32'h1, 4'hF);
      access("R8 shared config", 0, 'hC08, 0, 0);
      access("R8 private config", 0, 'hC04, 0, 0);
      access("R8 shared grpmod", 0, 'hD04, 0, 0);
      // R9 identification
      access("R9 periph2", 0, 'hFFE8, 0, 0);
      access("R9 periph2 shifted", 0, 'hFFEA, 0, 0);
      access("R9 other id", 0, 'hFFD0, 0, 0);
      access("R9 unmapped", 0, 'h5000, 0, 0);
      // R11 reset mid-run
      do_reset();
      access("R11 ctrl cleared", 0, 'h000, 0, 0);
      access("R11 route cleared", 0, 'h6000 + 8*95, 0, 0);
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule